// File: doc/BRIEF.md
# Keyboard Wake Key Detector

This block listens passively to a two-wire serial keyboard link (clock and data, both idle high) and raises a power-management event when the keyboard sends one chosen scan code. It runs from a slow 32 kHz sampling clock. Both keyboard lines are synchronized into that domain. A small state machine then assembles each 11-bit frame from the falling edges of the keyboard clock, and a comparator checks the framing bits and the parity. It also compares the data byte against a programmable wake code.

A match sets a sticky status flag, which stays set until a clear strobe arrives. When the event enable input is also high, the match drives a wake event pulse that is one cycle wide. The frame counter goes back to idle on its own after every 11th bit, so detection repeats frame after frame. The keyboard clock may stay high for too long in the middle of a frame. When that happens, the partial frame is thrown away, so that a glitch or a stalled transfer cannot leave the receiver misaligned and later produce a false event. An active-high off input freezes all detector state, which stands in for stopping its clock, and blocks events.

The receiver state machine has three states. `RX_IDLE` waits for a first falling edge and takes the transition *start* into `RX_SHIFT`, capturing bit 0. `RX_SHIFT` collects further bits. It takes *frame_done* into `RX_CHECK` on the 11th falling edge. It takes *stall_abort* back to `RX_IDLE` when the keyboard clock is seen high for `STALL_CYC` consecutive samples. `RX_CHECK` lasts one cycle, presents the frame to the comparator and takes *rearm* back to `RX_IDLE`.

Top module: `kbd_wake_detect`

## Requirements
- R1: After reset, `wake_evt` and `wake_sts` are both 0.
- R2: A frame is 11 bits captured on falling edges of `kb_clk`: bit 0 is a start bit of 0, bits 1..8 are the data byte LSB first, bit 9 is an odd parity bit (data plus parity hold an odd number of ones), and bit 10 is a stop bit of 1. When such a frame carries data equal to `wake_code`, `wake_evt` pulses high for exactly one `clk32` cycle and `wake_sts` becomes 1.
- R3: A well-formed frame whose data differs from `wake_code` produces no pulse and leaves `wake_sts` at 0.
- R4: A frame whose data matches but which has wrong parity, a start bit of 1 or a stop bit of 0 produces no pulse and no status.
- R5: The receiver returns to idle after every 11th bit without any idle gap, so two back-to-back matching frames give two pulses.
- R6: Between the first and the 11th falling edge, if `kb_clk` is sampled high for `STALL_CYC` (default 4) consecutive `clk32` cycles, the partial frame is discarded. A later complete frame is then received aligned from its own start bit.
- R7: While `wake_off` is 1, no frame is detected, no pulse is produced and `wake_sts` is not set. After a return to 0 (the reset default), detection works again.
- R8: With `evt_en` at 0, a matching frame produces no pulse but still sets `wake_sts`.
- R9: `wake_sts` stays 1 until `status_clr` is high at a clock edge, which clears it. A match at the same edge takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk32 | input | 1 | 32 kHz sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kb_clk | input | 1 | Keyboard clock line (idle high) |
| kb_dat | input | 1 | Keyboard data line (idle high) |
| wake_off | input | 1 | 1 turns the detector off and freezes it |
| evt_en | input | 1 | Lets a match drive the event output |
| wake_code | input | DATA_W | Scan code that causes a wake |
| status_clr | input | 1 | Clears the sticky status flag |
| wake_evt | output | 1 | One-cycle wake event pulse |
| wake_sts | output | 1 | Sticky match status |

## Verification
The bench builds the block with its defaults: an 8-bit code, a stall limit of 4 samples and two synchronizer stages. The 8-bit code keeps every possible data byte within reach, so for several wake codes the bench sends all 256 byte values and expects exactly one hit. The short stall limit allows a keyboard clock of four samples per bit, with two samples high, which stays safely under the limit. It also allows stalls of eight samples that must abort a partial frame. Framing errors, back-to-back frames and the off, enable and clear controls are each driven around a matching code.

// File: rtl/kbw_pkg.sv
package kbw_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_CHECK = 2'd2
    } rx_state_t;

    // Overhead bits around the data byte: start, parity, stop.
    localparam int FRAME_OVERHEAD = 3;

endpackage

// File: rtl/kbw_sync.sv
module kbw_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain[0] <= RST_VAL;
        end else if (en) begin
            chain[0] <= d;
        end
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[i] <= RST_VAL;
                end else if (en) begin
                    chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/kbw_rx_fsm.sv
module kbw_rx_fsm
    import kbw_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int STALL_CYC = 4,
    localparam int FRAME_W  = DATA_W + FRAME_OVERHEAD,
    localparam int BIT_CW   = $clog2(FRAME_W + 1),
    localparam int HI_CW    = $clog2(STALL_CYC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               kclk_s,
    input  logic               kdat_s,
    output logic [FRAME_W-1:0] frame,
    output logic               frame_vld
);

    rx_state_t          state, state_nx;
    logic               kclk_prev;
    logic               fall;
    logic               stall;
    logic [BIT_CW-1:0]  bit_cnt;
    logic [HI_CW-1:0]   hi_cnt;

    assign fall  = kclk_prev & ~kclk_s;
    assign stall = (state == RX_SHIFT) && kclk_s &&
                   (hi_cnt == HI_CW'(STALL_CYC - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else if (en) begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE: begin
                if (fall) state_nx = RX_SHIFT;               // start
            end
            RX_SHIFT: begin
                if (fall && bit_cnt == BIT_CW'(FRAME_W - 1))
                    state_nx = RX_CHECK;                     // frame_done
                else if (stall)
                    state_nx = RX_IDLE;                      // stall_abort
            end
            RX_CHECK: begin
                state_nx = RX_IDLE;                          // rearm
            end
            default: state_nx = RX_IDLE;
        endcase
    end

    // Datapath: edge history, shift register, counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kclk_prev <= 1'b1;
            frame     <= '0;
            bit_cnt   <= '0;
            hi_cnt    <= '0;
        end else if (en) begin
            kclk_prev <= kclk_s;

            if (fall && (state == RX_IDLE || state == RX_SHIFT))
                frame <= {kdat_s, frame[FRAME_W-1:1]};

            if (state == RX_IDLE && fall)
                bit_cnt <= BIT_CW'(1);
            else if (state == RX_SHIFT && fall)
                bit_cnt <= bit_cnt + BIT_CW'(1);
            else if (state_nx == RX_IDLE)
                bit_cnt <= '0;

            if (state == RX_SHIFT && kclk_s && !stall)
                hi_cnt <= hi_cnt + HI_CW'(1);
            else
                hi_cnt <= '0;
        end
    end

    // Outputs
    always_comb begin
        frame_vld = (state == RX_CHECK);
    end

endmodule

// File: rtl/kbw_match.sv
module kbw_match
    import kbw_pkg::*;
#(
    parameter int DATA_W   = 8,
    localparam int FRAME_W = DATA_W + FRAME_OVERHEAD
) (
    input  logic [FRAME_W-1:0] frame,
    input  logic [DATA_W-1:0]  code,
    output logic               hit
);

    logic              start_b, par_b, stop_b;
    logic [DATA_W-1:0] data_b;
    logic              framing_ok;

    always_comb begin
        start_b    = frame[0];
        data_b     = frame[DATA_W:1];
        par_b      = frame[DATA_W+1];
        stop_b     = frame[FRAME_W-1];
        framing_ok = !start_b && stop_b && ((^data_b) ^ par_b);
        hit        = framing_ok && (data_b == code);
    end

endmodule

// File: rtl/kbd_wake_detect.sv
module kbd_wake_detect
    import kbw_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int STALL_CYC   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk32,
    input  logic              rst_n,
    input  logic              kb_clk,
    input  logic              kb_dat,
    input  logic              wake_off,
    input  logic              evt_en,
    input  logic [DATA_W-1:0] wake_code,
    input  logic              status_clr,
    output logic              wake_evt,
    output logic              wake_sts
);

    localparam int FRAME_W = DATA_W + FRAME_OVERHEAD;

    logic               run;
    logic               kclk_s, kdat_s;
    logic [FRAME_W-1:0] frame;
    logic               frame_vld;
    logic               hit;
    logic               match;

    assign run = ~wake_off;

    kbw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
        .clk(clk32), .rst_n(rst_n), .en(run), .d(kb_clk), .q(kclk_s)
    );

    kbw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dat (
        .clk(clk32), .rst_n(rst_n), .en(run), .d(kb_dat), .q(kdat_s)
    );

    kbw_rx_fsm #(.DATA_W(DATA_W), .STALL_CYC(STALL_CYC)) u_rx (
        .clk(clk32), .rst_n(rst_n), .en(run),
        .kclk_s(kclk_s), .kdat_s(kdat_s),
        .frame(frame), .frame_vld(frame_vld)
    );

    kbw_match #(.DATA_W(DATA_W)) u_cmp (
        .frame(frame), .code(wake_code), .hit(hit)
    );

    assign match = run && frame_vld && hit;

    always_ff @(posedge clk32 or negedge rst_n) begin
        if (!rst_n) begin
            wake_evt <= 1'b0;
            wake_sts <= 1'b0;
        end else begin
            wake_evt <= match && evt_en;
            if (match)
                wake_sts <= 1'b1;
            else if (status_clr)
                wake_sts <= 1'b0;
        end
    end

endmodule

// File: rtl/kbw_checker.sv
module kbw_checker (
    input logic clk32,
    input logic rst_n,
    input logic wake_off,
    input logic evt_en,
    input logic status_clr,
    input logic wake_evt,
    input logic wake_sts
);

    // R2: the event pulse is exactly one cycle wide
    a_r2_single_pulse: assert property (@(posedge clk32) disable iff (!rst_n)
        wake_evt |=> !wake_evt);

    // R7: no event while the detector is off
    a_r7_off_quiet: assert property (@(posedge clk32) disable iff (!rst_n)
        wake_evt |-> !$past(wake_off));

    // R8: the event needs the enable
    a_r8_needs_enable: assert property (@(posedge clk32) disable iff (!rst_n)
        wake_evt |-> $past(evt_en));

    // R9: status holds without a clear
    a_r9_sticky: assert property (@(posedge clk32) disable iff (!rst_n)
        (wake_sts && !status_clr) |=> wake_sts);

    // R9: an event always comes with status set, even against a clear
    a_r9_evt_sets_sts: assert property (@(posedge clk32) disable iff (!rst_n)
        wake_evt |-> wake_sts);

endmodule

bind kbd_wake_detect kbw_checker u_chk (
    .clk32(clk32), .rst_n(rst_n), .wake_off(wake_off), .evt_en(evt_en),
    .status_clr(status_clr), .wake_evt(wake_evt), .wake_sts(wake_sts)
);

// File: tb/sim_kbd_wake_detect.sv
module sim_kbd_wake_detect;

    localparam int CLK_PERIOD = 10;

    logic       clk32 = 1'b0;
    logic       rst_n = 1'b0;
    logic       kb_clk = 1'b1;
    logic       kb_dat = 1'b1;
    logic       wake_off = 1'b0;
    logic       evt_en = 1'b1;
    logic [7:0] wake_code = 8'h00;
    logic       status_clr = 1'b0;
    logic       wake_evt, wake_sts;

    int n_chk = 0;
    int n_fail = 0;
    int evt_cnt = 0;
    int wide_cnt = 0;
    logic evt_prev = 1'b0;

    kbd_wake_detect u0 (
        .clk32(clk32), .rst_n(rst_n), .kb_clk(kb_clk), .kb_dat(kb_dat),
        .wake_off(wake_off), .evt_en(evt_en), .wake_code(wake_code),
        .status_clr(status_clr), .wake_evt(wake_evt), .wake_sts(wake_sts)
    );

    always #(CLK_PERIOD/2) clk32 = ~clk32;

    always @(negedge clk32) begin
        if (wake_evt) evt_cnt++;
        if (wake_evt && evt_prev) wide_cnt++;
        evt_prev = wake_evt;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [10:0] mk(input logic [7:0] d, input bit bad_par,
                                       input logic st, input logic sp);
        return {sp, (~^d) ^ bad_par, d, st};
    endfunction

    task automatic send_bits(input logic [21:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            kb_dat = bits[i];
            @(negedge clk32);
            kb_clk = 1'b0;
            @(negedge clk32);
            @(negedge clk32);
            kb_clk = 1'b1;
            @(negedge clk32);
        end
    endtask

    task automatic settle();
        kb_dat = 1'b1;
        repeat (10) @(negedge clk32);
        #1;
    endtask

    task automatic clear_sts();
        status_clr = 1'b1;
        @(negedge clk32);
        status_clr = 1'b0;
        @(negedge clk32);
    endtask

    // Send one frame, then check the pulse count and the status.
    task automatic frame_expect(input logic [10:0] f, input int exp_evt,
                                input bit exp_sts, input string req);
        int base;
        base = evt_cnt;
        send_bits({11'h7FF, f}, 11);
        settle();
        check(evt_cnt - base == exp_evt, req, evt_cnt - base, exp_evt);
        check(wake_sts == exp_sts, req, int'(wake_sts), int'(exp_sts));
        clear_sts();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] codes [3];
        int base;
        codes[0] = 8'h5A; codes[1] = 8'h00; codes[2] = 8'hFF;

        repeat (3) @(negedge clk32);
        #1;
        check(wake_evt == 1'b0, "R1 evt", int'(wake_evt), 0);
        check(wake_sts == 1'b0, "R1 sts", int'(wake_sts), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk32);

        // R2 / R3: every data byte against several wake codes
        foreach (codes[c]) begin
            wake_code = codes[c];
            for (int d = 0; d < 256; d++) begin
                if (8'(d) == codes[c])
                    frame_expect(mk(8'(d), 1'b0, 1'b0, 1'b1), 1, 1'b1, "R2 match");
                else
                    frame_expect(mk(8'(d), 1'b0, 1'b0, 1'b1), 0, 1'b0, "R3 miss");
            end
        end

        wake_code = 8'h1C;
        // R4: framing errors
        frame_expect(mk(8'h1C, 1'b1, 1'b0, 1'b1), 0, 1'b0, "R4 parity");
        frame_expect(mk(8'h1C, 1'b0, 1'b1, 1'b1), 0, 1'b0, "R4 start");
        frame_expect(mk(8'h1C, 1'b0, 1'b0, 1'b0), 0, 1'b0, "R4 stop");

        // R5: two frames back to back
        base = evt_cnt;
        send_bits({mk(8'h1C, 1'b0, 1'b0, 1'b1), mk(8'h1C, 1'b0, 1'b0, 1'b1)}, 22);
        settle();
        check(evt_cnt - base == 2, "R5 back-to-back", evt_cnt - base, 2);
        clear_sts();

        // R6: partial frame, stall, then a full frame
        send_bits({11'h7FF, mk(8'h1C, 1'b0, 1'b0, 1'b1)}, 5);
        repeat (8) @(negedge clk32);
        frame_expect(mk(8'h1C, 1'b0, 1'b0, 1'b1), 1, 1'b1, "R6 realign");

        // R6: a stall splits a matching frame, so nothing matches
        base = evt_cnt;
        send_bits({11'h7FF, mk(8'h1C, 1'b0, 1'b0, 1'b1)}, 4);
        repeat (8) @(negedge clk32);
        send_bits({15'h7FFF, mk(8'h1C, 1'b0, 1'b0, 1'b1) >> 4}, 7);
        settle();
        repeat (8) @(negedge clk32);
        #1;
        check(evt_cnt - base == 0, "R6 split", evt_cnt - base, 0);
        check(wake_sts == 1'b0, "R6 split sts", int'(wake_sts), 0);
        frame_expect(mk(8'h1C, 1'b0, 1'b0, 1'b1), 1, 1'b1, "R6 after split");

        // R7: detector off, then back on
        wake_off = 1'b1;
        frame_expect(mk(8'h1C, 1'b0, 1'b0, 1'b1), 0, 1'b0, "R7 off");
        wake_off = 1'b0;
        @(negedge clk32);
        frame_expect(mk(8'h1C, 1'b0, 1'b0, 1'b1), 1, 1'b1, "R7 on again");

        // R8: event disabled, status still set
        evt_en = 1'b0;
        frame_expect(mk(8'h1C, 1'b0, 1'b0, 1'b1), 0, 1'b1, "R8 no event");
        evt_en = 1'b1;

        // R9: status sticky until cleared
        send_bits({11'h7FF, mk(8'h1C, 1'b0, 1'b0, 1'b1)}, 11);
        settle();
        repeat (20) @(negedge clk32);
        #1;
        check(wake_sts == 1'b1, "R9 sticky", int'(wake_sts), 1);
        clear_sts();
        #1;
        check(wake_sts == 1'b0, "R9 cleared", int'(wake_sts), 0);

        check(wide_cnt == 0, "R2 pulse width", wide_cnt, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule